// File: doc/BRIEF.md
# Multithreaded Issue Slot Scheduler

This block decides, on every clock cycle, which hardware thread context may place one instruction into a shared in-order pipeline. Each cycle is one issue slot. The slot is either granted to exactly one thread or left empty as a bubble. The chosen thread index leaves the block together with the valid flag. Later stages use it to reach the correct per-thread program counter and register state.

Three policies can be chosen at run time. In the barrel policy the slot owner rotates through the threads in index order. In the table policy the owner comes from a slot table of eight entries that software loads through a simple write port. In the demand policy the hardware grants the ready thread that has the fewest instructions in flight. The first two policies never hand an unused slot to another thread: if the owner is not ready, the slot becomes a bubble.

The issue output is a plain per-cycle stream with no back-pressure. The downstream pipeline must accept a slot on every cycle. A bubble is shown by `issue_valid` low, and the thread field then reads zero. The outputs are combinational from the registered pointers, the registered policy, the slot table and the current ready and count inputs.

Top module: `iss_sched`

## Requirements
- R1: An active-high synchronous `rst` sets the rotation and slot pointers to 0, selects the barrel policy, and loads slot table entry i with i mod 4. In the first cycle after release under the barrel policy with all threads ready, thread 0 issues.
- R2: Barrel policy (`policy_sel` = 0): in the k-th cycle after reset release, counting from 0, the owner is thread k mod 4. Both pointers advance every cycle whatever policy is active.
- R3: Barrel policy: if the owner's `thread_ready` bit is low, the slot is a bubble. No other thread issues in that slot.
- R4: Table policy (`policy_sel` = 1): in the k-th cycle after release, the slot table entry k mod 8 names the owner. The owner issues if it is ready; otherwise the slot is a bubble.
- R5: Table policy: an entry whose 3-bit value is 4 or greater is an empty slot and always gives a bubble.
- R6: Demand policy (`policy_sel` = 2): the ready thread with the smallest count in `inflight_cnt` issues. Thread t's count is bits [4t+3:4t]. When counts are equal, the lowest index wins.
- R7: Demand policy with no ready thread gives a bubble.
- R8: `policy_sel` is sampled at each clock edge. A new value governs the slot after that edge, and the slot in progress keeps the old policy.
- R9: A table write (`tbl_wr_en` high, `tbl_wr_slot`, `tbl_wr_tid`) takes effect at the clock edge. It is visible from the next cycle on.
- R10: During a bubble `issue_tid` is 0. A granted thread is always one whose ready bit is high.
- R11: Policy code 3 behaves exactly like the demand policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| policy_sel | input | 2 | 0 barrel, 1 table, 2 or 3 demand |
| thread_ready | input | 4 | Per-thread ready flag, bit t for thread t |
| inflight_cnt | input | 16 | Per-thread in-flight count, 4 bits each |
| tbl_wr_en | input | 1 | Slot table write strobe |
| tbl_wr_slot | input | 3 | Slot table entry to write |
| tbl_wr_tid | input | 3 | Thread index to store; 4 to 7 mark an empty slot |
| issue_valid | output | 1 | High when a thread issues in this slot |
| issue_tid | output | 2 | Granted thread index, 0 during a bubble |

## Verification
Some rules hold in every cycle, and the assertions check those. A bubble carries thread zero. A grant only ever goes to a ready thread. No ready thread means a bubble. Under demand policy no ready thread beats the granted one. The registered policy follows the previous cycle's select. Under the barrel policy the owner matches a rotation counted from reset.

Other behaviour needs a known history, and only the bench scenarios can show it. This covers slot table contents, empty-slot entries, when a table write becomes visible, the restored table after a second reset, and the slot where a policy change takes effect.

// File: rtl/iss_pkg.sv
package iss_pkg;
  typedef enum logic [1:0] {
    POL_BARREL = 2'd0,
    POL_TABLE  = 2'd1,
    POL_DEMAND = 2'd2,
    POL_DEMAND_ALT = 2'd3
  } pol_e;
endpackage

// File: rtl/iss_wrap_ctr.sv
module iss_wrap_ctr #(
  parameter int LIMIT = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/iss_slot_table.sv
module iss_slot_table #(
  parameter int NTHREADS = 4,
  parameter int NSLOTS   = 8,
  parameter int ENTRY_W  = 3,
  localparam int SLOT_W  = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SLOT_W-1:0]  wr_slot,
  input  logic [ENTRY_W-1:0] wr_tid,
  input  logic [SLOT_W-1:0]  rd_slot,
  output logic [ENTRY_W-1:0] rd_entry
);
  logic [ENTRY_W-1:0] entry_q [NSLOTS];

  for (genvar s = 0; s < NSLOTS; s++) begin : g_entry
    localparam logic [ENTRY_W-1:0] INIT = ENTRY_W'(s % NTHREADS);
    always_ff @(posedge clk) begin
      if (rst)                                  entry_q[s] <= INIT;
      else if (wr_en && wr_slot == SLOT_W'(s))  entry_q[s] <= wr_tid;
    end
  end

  assign rd_entry = entry_q[rd_slot];
endmodule

// File: rtl/iss_least_pick.sv
module iss_least_pick #(
  parameter int NTHREADS = 4,
  parameter int CNT_W    = 4,
  localparam int TID_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic [NTHREADS-1:0]       ready,
  input  logic [NTHREADS*CNT_W-1:0] counts,
  output logic                      found,
  output logic [TID_W-1:0]          tid
);
  logic [CNT_W-1:0] best_cnt;

  // Linear scan; strict less-than keeps the lowest index on ties.
  always_comb begin
    found    = 1'b0;
    tid      = '0;
    best_cnt = '0;
    for (int i = 0; i < NTHREADS; i++) begin
      if (ready[i] && (!found || counts[i*CNT_W +: CNT_W] < best_cnt)) begin
        found    = 1'b1;
        tid      = TID_W'(i);
        best_cnt = counts[i*CNT_W +: CNT_W];
      end
    end
  end
endmodule

// File: rtl/iss_sched.sv
module iss_sched
  import iss_pkg::*;
#(
  parameter int NTHREADS = 4,
  parameter int NSLOTS   = 8,
  parameter int ENTRY_W  = 3,
  parameter int CNT_W    = 4,
  localparam int TID_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
  localparam int SLOT_W  = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                policy_sel,
  input  logic [NTHREADS-1:0]       thread_ready,
  input  logic [NTHREADS*CNT_W-1:0] inflight_cnt,
  input  logic                      tbl_wr_en,
  input  logic [SLOT_W-1:0]         tbl_wr_slot,
  input  logic [ENTRY_W-1:0]        tbl_wr_tid,
  output logic                      issue_valid,
  output logic [TID_W-1:0]          issue_tid
);
  pol_e               policy_q;
  logic [TID_W-1:0]   rr_ptr;
  logic [SLOT_W-1:0]  slot_ptr;
  logic [ENTRY_W-1:0] tbl_entry;
  logic               pick_found;
  logic [TID_W-1:0]   pick_tid;
  logic               cand_ok;
  logic [TID_W-1:0]   cand_tid;

  always_ff @(posedge clk) begin
    if (rst) policy_q <= POL_BARREL;
    else     policy_q <= pol_e'(policy_sel);
  end

  iss_wrap_ctr #(.LIMIT(NTHREADS), .W(TID_W)) u_rr_ctr (
    .clk(clk), .rst(rst), .cnt(rr_ptr)
  );

  iss_wrap_ctr #(.LIMIT(NSLOTS), .W(SLOT_W)) u_slot_ctr (
    .clk(clk), .rst(rst), .cnt(slot_ptr)
  );

  iss_slot_table #(.NTHREADS(NTHREADS), .NSLOTS(NSLOTS), .ENTRY_W(ENTRY_W)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(tbl_wr_en), .wr_slot(tbl_wr_slot), .wr_tid(tbl_wr_tid),
    .rd_slot(slot_ptr), .rd_entry(tbl_entry)
  );

  iss_least_pick #(.NTHREADS(NTHREADS), .CNT_W(CNT_W)) u_pick (
    .ready(thread_ready), .counts(inflight_cnt),
    .found(pick_found), .tid(pick_tid)
  );

  always_comb begin
    cand_ok  = 1'b0;
    cand_tid = '0;
    unique case (policy_q)
      POL_BARREL: begin
        cand_tid = rr_ptr;
        cand_ok  = thread_ready[rr_ptr];
      end
      POL_TABLE: begin
        cand_tid = tbl_entry[TID_W-1:0];
        cand_ok  = (int'(tbl_entry) < NTHREADS) && thread_ready[tbl_entry[TID_W-1:0]];
      end
      default: begin
        cand_tid = pick_tid;
        cand_ok  = pick_found;
      end
    endcase
  end

  assign issue_valid = cand_ok;
  assign issue_tid   = cand_ok ? cand_tid : '0;
endmodule

// File: rtl/iss_sched_chk.sv
module iss_sched_chk #(
  parameter int NTHREADS = 4,
  parameter int CNT_W    = 4,
  localparam int TID_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input logic                      clk,
  input logic                      rst,
  input logic [1:0]                policy_sel,
  input logic [1:0]                policy_q,
  input logic [NTHREADS-1:0]       thread_ready,
  input logic [NTHREADS*CNT_W-1:0] inflight_cnt,
  input logic                      issue_valid,
  input logic [TID_W-1:0]          issue_tid
);
  logic [TID_W-1:0] rot_model;
  logic             better_exists;

  always_ff @(posedge clk) begin
    if (rst)                                rot_model <= '0;
    else if (int'(rot_model) == NTHREADS-1) rot_model <= '0;
    else                                    rot_model <= rot_model + 1'b1;
  end

  always_comb begin
    better_exists = 1'b0;
    for (int i = 0; i < NTHREADS; i++) begin
      if (thread_ready[i]) begin
        if (inflight_cnt[i*CNT_W +: CNT_W] < inflight_cnt[issue_tid*CNT_W +: CNT_W])
          better_exists = 1'b1;
        if (inflight_cnt[i*CNT_W +: CNT_W] == inflight_cnt[issue_tid*CNT_W +: CNT_W]
            && i < int'(issue_tid))
          better_exists = 1'b1;
      end
    end
  end

  // R10
  bubble_tid_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |-> issue_tid == '0);

  // R10
  grant_is_ready_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> thread_ready[issue_tid]);

  // R7
  none_ready_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    thread_ready == '0 |-> !issue_valid);

  // R6
  least_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (policy_q[1] && issue_valid) |-> !better_exists);

  // R7
  demand_no_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (policy_q[1] && thread_ready != '0) |-> issue_valid);

  // R2
  rotation_order_chk: assert property (@(posedge clk) disable iff (rst)
    (policy_q == 2'd0 && issue_valid) |-> issue_tid == rot_model);

  // R8
  policy_latch_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> policy_q == $past(policy_sel));
endmodule

bind iss_sched iss_sched_chk #(.NTHREADS(NTHREADS), .CNT_W(CNT_W)) u_iss_chk (
  .clk(clk), .rst(rst), .policy_sel(policy_sel), .policy_q(policy_q),
  .thread_ready(thread_ready), .inflight_cnt(inflight_cnt),
  .issue_valid(issue_valid), .issue_tid(issue_tid)
);

// File: tb/iss_sched_test.sv
module iss_sched_test;
  localparam int N  = 4;
  localparam int S  = 8;
  localparam int EW = 3;
  localparam int CW = 4;
  localparam int NV = 10;

  // {ready[22:19], counts[18:3], valid[2], tid[1:0]}
  localparam logic [22:0] VEC [NV] = '{
    {4'b1111, 16'h3210, 1'b1, 2'd0},
    {4'b1111, 16'h0123, 1'b1, 2'd3},
    {4'b1111, 16'h5555, 1'b1, 2'd0},
    {4'b1110, 16'h5555, 1'b1, 2'd1},
    {4'b0000, 16'h1234, 1'b0, 2'd0},
    {4'b1010, 16'h1020, 1'b1, 2'd3},
    {4'b0110, 16'h0770, 1'b1, 2'd1},
    {4'b1000, 16'hF000, 1'b1, 2'd3},
    {4'b1001, 16'hF00F, 1'b1, 2'd0},
    {4'b0101, 16'h0A0B, 1'b1, 2'd2}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    policy_sel;
  logic [N-1:0]  thread_ready;
  logic [N*CW-1:0] inflight_cnt;
  logic          tbl_wr_en;
  logic [2:0]    tbl_wr_slot;
  logic [EW-1:0] tbl_wr_tid;
  logic          issue_valid;
  logic [1:0]    issue_tid;

  int checks = 0;
  int fails  = 0;
  int cyc;
  logic [1:0]    pol_eff;
  logic [EW-1:0] mtab [S];

  always #2 clk = ~clk;

  iss_sched #(.NTHREADS(N), .NSLOTS(S), .ENTRY_W(EW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .policy_sel(policy_sel), .thread_ready(thread_ready),
    .inflight_cnt(inflight_cnt), .tbl_wr_en(tbl_wr_en), .tbl_wr_slot(tbl_wr_slot),
    .tbl_wr_tid(tbl_wr_tid), .issue_valid(issue_valid), .issue_tid(issue_tid)
  );

  task automatic compare(string tag, logic ev, logic [1:0] et);
    checks++;
    if (issue_valid !== ev || issue_tid !== et) begin
      fails++;
      $display("FAIL %s: actual valid=%0b tid=%0d expected valid=%0b tid=%0d",
               tag, issue_valid, issue_tid, ev, et);
    end
  endtask

  // Expected slot outcome derived from the requirements.
  task automatic check_now(string tag);
    logic ev;
    logic [1:0] et;
    logic [EW-1:0] e;
    int rr, sl, best;
    #1;
    rr = cyc % N; sl = cyc % S; ev = 1'b0; et = 2'd0; best = -1;
    if (pol_eff == 2'd0) begin
      if (thread_ready[rr]) begin ev = 1'b1; et = 2'(rr); end
    end else if (pol_eff == 2'd1) begin
      e = mtab[sl];
      if (int'(e) < N && thread_ready[e[1:0]]) begin ev = 1'b1; et = e[1:0]; end
    end else begin
      for (int i = 0; i < N; i++)
        if (thread_ready[i] && (best < 0 ||
            inflight_cnt[i*CW +: CW] < inflight_cnt[best*CW +: CW])) best = i;
      if (best >= 0) begin ev = 1'b1; et = 2'(best); end
    end
    compare(tag, ev, et);
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst) begin
      cyc = 0; pol_eff = 2'd0;
      for (int s = 0; s < S; s++) mtab[s] = EW'(s % N);
    end else begin
      cyc++;
      pol_eff = policy_sel;
      if (tbl_wr_en) mtab[tbl_wr_slot] = tbl_wr_tid;
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [2:0] nxt;
    rst = 1'b1; policy_sel = 2'd0; thread_ready = '0; inflight_cnt = '0;
    tbl_wr_en = 1'b0; tbl_wr_slot = '0; tbl_wr_tid = '0;
    cyc = 0; pol_eff = 2'd0;
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    thread_ready = 4'hF;

    // R1 first slot after release, then R2 rotation
    check_now("R1 reset state");
    tick();
    for (int k = 1; k < 8; k++) begin
      check_now("R2 barrel rotation");
      tick();
    end

    // R9 load the slot table while the barrel policy runs
    for (int s = 0; s < S; s++) begin
      tbl_wr_en = 1'b1;
      tbl_wr_slot = 3'(s);
      case (s)
        0: tbl_wr_tid = 3'd3;  1: tbl_wr_tid = 3'd2;
        2: tbl_wr_tid = 3'd6;  3: tbl_wr_tid = 3'd1;
        4: tbl_wr_tid = 3'd0;  5: tbl_wr_tid = 3'd4;
        6: tbl_wr_tid = 3'd2;  default: tbl_wr_tid = 3'd3;
      endcase
      check_now("R2 barrel during table load");
      tick();
    end
    tbl_wr_en = 1'b0;

    // R3 owner not ready gives a bubble
    thread_ready = 4'b1011;
    for (int k = 0; k < 4; k++) begin
      check_now("R3 barrel bubble");
      tick();
    end

    // R8 switch to table policy
    thread_ready = 4'hF;
    policy_sel = 2'd1;
    check_now("R8 old policy holds");
    tick();
    check_now("R8 new policy");
    tick();
    for (int k = 0; k < 16; k++) begin
      check_now("R4 table order, R5 empty slots");
      tick();
    end
    thread_ready = 4'b1101;
    for (int k = 0; k < 8; k++) begin
      check_now("R4 table owner not ready");
      tick();
    end

    // R9 write the next slot and see it one cycle later
    thread_ready = 4'hF;
    nxt = 3'((cyc + 1) % S);
    tbl_wr_en = 1'b1; tbl_wr_slot = nxt;
    tbl_wr_tid = (mtab[nxt] == 3'd0) ? 3'd1 : 3'd0;
    check_now("R9 write cycle");
    tick();
    tbl_wr_en = 1'b0;
    check_now("R9 written entry visible");
    tick();

    // R6/R7 demand policy vectors
    policy_sel = 2'd2;
    check_now("R8 switch to demand");
    tick();
    for (int v = 0; v < NV; v++) begin
      thread_ready = VEC[v][22:19];
      inflight_cnt = VEC[v][18:3];
      #1;
      compare(VEC[v][2] ? "R6 demand pick" : "R7 demand bubble", VEC[v][2], VEC[v][1:0]);
      tick();
    end

    // R11 code 3 acts as demand
    policy_sel = 2'd3;
    tick();
    thread_ready = 4'b0110; inflight_cnt = 16'h0120;
    #1;
    compare("R11 code 3 demand", 1'b1, 2'd2);
    tick();

    // R1 second reset restores the table
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    thread_ready = 4'hF; policy_sel = 2'd1;
    check_now("R1 reset to barrel");
    tick();
    for (int k = 1; k < 9; k++) begin
      check_now("R1 table restored");
      tick();
    end

    summary();
    $finish;
  end
endmodule